// File: doc/BRIEF.md
# SCL Clock Divider Generator

This block turns a fast peripheral clock into the serial clock of a two-wire bus master. The high and low phases of the clock are programmed on their own, each from one 16-bit half of a single 32-bit divider word. A free-running divide-by-eight prescaler paces a phase counter, so every phase is a whole multiple of eight input cycles. A field value N gives a phase of (N+1)·8 input cycles. This makes a duty cycle other than 50% possible, and equal fields give an exactly symmetric clock.

The bit-level controller uses the serial clock level and four single-cycle strobes. Two strobes mark the first cycle of each low and each high phase, where data may change or a bit begins. The other two mark the midpoint of each phase, where data is sampled. A divider word written while the clock runs is held off until the next rising edge of the clock, so no phase in progress is ever cut short or stretched.

Top module: `scl_clk_gen`

## Requirements
- R1: While reset (synchronous, active low) is applied or enable is low, from the following clock edge onward scl is 1 and all four strobes are 0.
- R2: On the first clock edge that sees enable high while idle, scl goes to 0, so the first phase generated is always the low phase.
- R3: Each low phase lasts exactly (L+1)·8 input cycles, where L is div_word[15:0].
- R4: Each high phase lasts exactly (H+1)·8 input cycles, where H is div_word[31:16].
- R5: A field value of 0 is legal and gives a phase of 8 input cycles.
- R6: One full scl period is 8·(H+L+2) input cycles. With H equal to L, the low and high phases have the same length.
- R7: A divider word is taken only at the edge where scl rises (and while idle). The low phase in progress keeps its old L, the high phase that starts at that edge uses the new H, and a word written during a high phase has no effect until the next rising edge.
- R8: fall_stb is 1 only in the first cycle of each low phase, and rise_stb only in the first cycle of each high phase. Each lasts one cycle.
- R9: Counting the first cycle of a phase as index 0, high_mid_stb is 1 only at index 4·(H+1) of a high phase, and low_mid_stb only at index 4·(L+1) of a low phase.
- R10: Dropping enable in the middle of a phase returns scl to 1 on the next edge without a rise_stb. A later enable starts a fresh low phase of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the divider; low forces idle with scl high |
| div_word | input | 32 | High-phase field in [31:16], low-phase field in [15:0] |
| scl | output | 1 | Serial clock level |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| high_mid_stb | output | 1 | Midpoint cycle of a high phase |
| low_mid_stb | output | 1 | Midpoint cycle of a low phase |

## Verification
The embedded properties assume that div_word is driven to a known value whenever reset is released or enable is high. They also assume that the phase count is compared against a shadow value that does not move within a phase. The bench therefore changes div_word only at sampling points away from the clock edge, and it holds each word until at least one rising edge has captured it. Random field values are kept small so that many full periods fit in the run. Directed cases add zero fields, equal fields, a large low field, writes during both phases and a mid-phase disable.

// File: rtl/scl_div_pkg.sv
// Package: shared defaults and the phase encoding for the serial clock divider.
// Assumes: nothing; pure declarations.
package scl_div_pkg;
    localparam int DEF_HALF_W = 16;   // width of each phase field
    localparam int DEF_PRE_W  = 3;    // prescaler bits (divide by 2**PRE_W = 8)

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/scl_prescale.sv
// Module: free-running power-of-two prescaler.
// Does: counts input cycles while run is high and flags the last count (tc).
// Assumes: run rises in the same cycle the phase logic starts a phase, so the
// count is zero in that phase's first cycle.
module scl_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [PRE_W-1:0] pre,
    output logic             tc
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    // Purpose: advance the prescale count, clear it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign tc = run && (pre == PRE_LAST);

    // R3
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (pre == PRE_W'($past(pre) + 1'b1)));
endmodule

// File: rtl/scl_div_shadow.sv
// Module: shadow copy of the divider word.
// Does: captures the high and low fields when load is high and holds them otherwise.
// Assumes: load is high while idle and at the edge where scl rises.
module scl_div_shadow #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [2*HALF_W-1:0] word_in,
    output logic [HALF_W-1:0] hi_lim,
    output logic [HALF_W-1:0] lo_lim
);
    // Purpose: hold the active phase limits, refresh only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_lim <= '0;
            lo_lim <= '0;
        end else if (load) begin
            hi_lim <= word_in[2*HALF_W-1:HALF_W];
            lo_lim <= word_in[HALF_W-1:0];
        end
    end

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(hi_lim) && $stable(lo_lim)));
endmodule

// File: rtl/scl_phase_ctrl.sv
// Module: phase sequencer.
// Does: keeps scl high when idle, starts with a low phase, and counts prescaler
// wraps until the current phase limit is reached. Then it flips scl.
// Assumes: tc is high for one cycle per prescaler wrap, and the limits only
// change at the rise event this module reports.
module scl_phase_ctrl
    import scl_div_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tc,
    input  logic [HALF_W-1:0] hi_lim,
    input  logic [HALF_W-1:0] lo_lim,
    output logic              running,
    output logic              scl,
    output logic [HALF_W-1:0] cnt,
    output logic              rise_evt
);
    scl_phase_e       phase;
    logic [HALF_W-1:0] lim;
    logic              at_lim;

    assign lim      = (phase == PH_HIGH) ? hi_lim : lo_lim;
    assign at_lim   = (cnt == lim);
    assign rise_evt = running && tc && (phase == PH_LOW) && at_lim;
    assign scl      = (phase == PH_HIGH);

    // Purpose: sequence idle, low and high phases and count prescaler wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running <= 1'b0;
            phase   <= PH_HIGH;
            cnt     <= '0;
        end else if (!running) begin
            running <= 1'b1;
            phase   <= PH_LOW;
            cnt     <= '0;
        end else if (tc) begin
            if (at_lim) begin
                phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl && !running));
    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !$past(running)) |-> !scl);
    // R3
    flip_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$stable(scl)) |-> $past(tc));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= lim));
endmodule

// File: rtl/scl_strobe_dec.sv
// Module: strobe decoder.
// Does: forms the phase index {cnt, pre} and decodes the edge and midpoint strobes.
// Assumes: the index is zero in the first cycle of every phase and rises by one each cycle.
module scl_strobe_dec #(
    parameter int HALF_W = 16,
    parameter int PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              scl,
    input  logic [HALF_W-1:0] cnt,
    input  logic [PRE_W-1:0]  pre,
    input  logic [HALF_W-1:0] hi_lim,
    input  logic [HALF_W-1:0] lo_lim,
    output logic              fall_stb,
    output logic              rise_stb,
    output logic              high_mid_stb,
    output logic              low_mid_stb
);
    localparam int IDX_W = HALF_W + PRE_W;

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] hi_mid_idx;
    logic [IDX_W-1:0] lo_mid_idx;

    // Purpose: half of a phase length, (lim+1) * 2**(PRE_W-1).
    always_comb begin
        idx        = {cnt, pre};
        hi_mid_idx = ({{PRE_W{1'b0}}, hi_lim} + IDX_W'(1)) << (PRE_W - 1);
        lo_mid_idx = ({{PRE_W{1'b0}}, lo_lim} + IDX_W'(1)) << (PRE_W - 1);
    end

    // Purpose: decode the four single-cycle strobes.
    always_comb begin
        fall_stb     = running && !scl && (idx == '0);
        rise_stb     = running &&  scl && (idx == '0);
        high_mid_stb = running &&  scl && (idx == hi_mid_idx);
        low_mid_stb  = running && !scl && (idx == lo_mid_idx);
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, rise_stb, high_mid_stb, low_mid_stb}));
    // R8
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
    // R9
    mid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (high_mid_stb |-> scl) and (low_mid_stb |-> !scl));
endmodule

// File: rtl/scl_clk_gen.sv
// Module: top of the serial clock divider.
// Does: wires prescaler, shadow limits, phase sequencer and strobe decoder.
// Assumes: clk is the peripheral clock and rst_n is synchronous to it.
module scl_clk_gen
    import scl_div_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W,
    parameter int PRE_W  = DEF_PRE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [2*HALF_W-1:0] div_word,
    output logic                scl,
    output logic                fall_stb,
    output logic                rise_stb,
    output logic                high_mid_stb,
    output logic                low_mid_stb
);
    logic              running;
    logic              tc;
    logic              rise_evt;
    logic              load;
    logic [PRE_W-1:0]  pre;
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] hi_lim;
    logic [HALF_W-1:0] lo_lim;

    // Purpose: refresh the limits while idle or exactly at a rising scl edge.
    assign load = !running || rise_evt;

    scl_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .pre(pre), .tc(tc)
    );

    scl_div_shadow #(.HALF_W(HALF_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load), .word_in(div_word),
        .hi_lim(hi_lim), .lo_lim(lo_lim)
    );

    scl_phase_ctrl #(.HALF_W(HALF_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tc(tc),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .running(running),
        .scl(scl), .cnt(cnt), .rise_evt(rise_evt)
    );

    scl_strobe_dec #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .running(running), .scl(scl),
        .cnt(cnt), .pre(pre), .hi_lim(hi_lim), .lo_lim(lo_lim),
        .fall_stb(fall_stb), .rise_stb(rise_stb),
        .high_mid_stb(high_mid_stb), .low_mid_stb(low_mid_stb)
    );

    // R10
    drop_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rise_stb);
endmodule

// File: tb/scl_clk_gen_test.sv
module scl_clk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [31:0] div_word;
    logic        scl, fall_stb, rise_stb, high_mid_stb, low_mid_stb;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    scl_clk_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_word(div_word),
        .scl(scl), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .high_mid_stb(high_mid_stb), .low_mid_stb(low_mid_stb)
    );

    function automatic int plen(input int f);
        return (f + 1) * 8;
    endfunction

    function automatic int pmid(input int f);
        return (f + 1) * 4;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk({req, " scl level"}, scl, 1);
        chk({req, " strobes"}, {fall_stb, rise_stb, high_mid_stb, low_mid_stb}, 0);
    endtask

    // Called at the sampling point of the first cycle of a phase. Returns at the
    // first cycle of the next phase.
    task automatic measure_phase(input logic lvl, input int fld, input string req,
                                 output int len);
        int n = 0;
        int midbad = 0;
        int extra = 0;
        int lim = plen(fld) + 16;
        chk("R8 phase-start strobe", lvl ? rise_stb : fall_stb, 1);
        while (scl === lvl && n < lim) begin
            logic m;
            m = lvl ? high_mid_stb : low_mid_stb;
            if (m !== (n == pmid(fld))) midbad++;
            if (n > 0 && (rise_stb || fall_stb)) extra++;
            n++;
            @(negedge clk);
        end
        len = n;
        chk(req, n, plen(fld));
        chk("R9 midpoint strobe errors", midbad, 0);
        chk("R8 stray edge strobes", extra, 0);
    endtask

    task automatic run_case(input int h, input int l);
        int lo1, hi1, lo2;
        enable   = 1'b0;
        div_word = {16'(h), 16'(l)};
        repeat (2) @(negedge clk);
        chk_idle("R1 idle before start");
        enable = 1'b1;
        @(negedge clk);
        chk("R2 first phase low", scl, 0);
        measure_phase(1'b0, l, (l == 0) ? "R5 zero low field" : "R3 low length", lo1);
        measure_phase(1'b1, h, (h == 0) ? "R5 zero high field" : "R4 high length", hi1);
        measure_phase(1'b0, l, "R3 second low length", lo2);
        chk("R6 period", lo1 + hi1, 8 * (h + l + 2));
        if (h == l) chk("R6 equal halves", lo1, hi1);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int dummy;
        int tmp;
        void'($urandom(32'd2718));
        rst_n    = 1'b0;
        enable   = 1'b1;
        div_word = 32'h0001_0002;
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        enable = 1'b0;
        rst_n  = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R1 after reset");

        run_case(0, 0);
        run_case(0, 5);
        run_case(7, 0);
        run_case(3, 3);
        run_case(1, 12'hFFF);
        run_case(16'h0800, 0);
        for (int i = 0; i < 10; i++) begin
            run_case(int'($urandom % 64), int'($urandom % 64));
        end

        // R7: write during low, then during high
        enable   = 1'b0;
        div_word = {16'd2, 16'd3};
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        div_word = {16'd5, 16'd1};
        measure_phase(1'b0, 3, "R7 low keeps old field", dummy);
        div_word = {16'd1, 16'd0};
        measure_phase(1'b1, 5, "R7 high takes new field", dummy);
        measure_phase(1'b0, 1, "R7 write in high ignored for next low", dummy);
        measure_phase(1'b1, 1, "R7 later high uses latest", dummy);
        measure_phase(1'b0, 0, "R7 later low uses latest", dummy);

        // R10: drop enable mid low phase
        enable   = 1'b0;
        div_word = {16'd3, 16'd4};
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (11) @(negedge clk);
        chk("R10 still low mid phase", scl, 0);
        enable = 1'b0;
        @(negedge clk);
        chk_idle("R10 drop");
        repeat (3) @(negedge clk);
        chk_idle("R10 held idle");
        enable = 1'b1;
        @(negedge clk);
        chk("R10 restart low", scl, 0);
        measure_phase(1'b0, 4, "R10 fresh low full length", tmp);
        measure_phase(1'b1, 3, "R10 high after restart", tmp);
        enable = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule